// File: doc/BRIEF.md
# Per-Master Bus Access Permission Controller

This block screens bus requests before they reach a set of downstream peripheral regions. Every request arrives with a region index, the identity of the master that issued it (core 0, core 1, DMA engine or debugger), a security attribute and a privilege attribute. The block looks up the 8-bit permission word of the addressed region and raises `req_allow` in the same cycle when both the master and its security/privilege context are granted. The decision is purely combinational and adds no cycle to the request path.

The permission words are programmed through a 32-bit register write/read port. Each configuration write also carries the identity of the master that issues it. Software can also use this port for three further controls:
- A sticky per-master lock register. Once a master's lock bit is set, its configuration writes are dropped without any error.
- A force-non-secure control that makes every core 1 request count as Non-secure.
- A self-clearing command that puts every region word back to its built-in default.

Each region's default comes from one of four classes, chosen per region by a parameter. The reset input is asynchronous and active low. It is expected to be released in step with the clock.

Top module: `bus_perm_ctrl`

## Requirements
- R1: After reset the lock register reads 0x4, the force register reads 0, the clear register reads 0, and each region word reads its class default. The class codes and their defaults are:
  - class 0: 0xFF
  - class 1: 0xFC
  - class 2: 0xB8
  - class 3: 0xF8
  Region i takes its class from bits [2i+1:2i] of `REGION_CLASS`.
- R2: Master codes on `req_master`/`cfg_master` are 0 core 0, 1 core 1, 2 DMA, 3 debugger. A request is allowed only if bit 4+code of the region word is 1.
- R3: Region word bit 3 grants Secure-Privileged and bit 1 grants Non-secure-Privileged access. A privileged request is allowed only if the bit for its security state is 1.
- R4: A Secure-Unprivileged request needs both bit 2 and bit 3. A Non-secure-Unprivileged request needs both bit 0 and bit 1.
- R5: A region index of `NUM_REGIONS` or more is never allowed. `req_allow` follows the request inputs and the current words in the same cycle, with no register in between.
- R6: The register map uses word addresses on `cfg_addr`:
  - 0: lock, bits [3:0], one bit per master code
  - 1: force-non-secure, bit 1
  - 2: clear, bit 0
  - 4+i: region i, bits [7:0]
  A write takes effect at the clock edge where `cfg_wr` is sampled. `cfg_rdata` shows the addressed register combinationally, zero-extended. Unmapped addresses read 0.
- R7: A write to the lock register sets the lock bits that are 1 in the data. A lock bit is cleared only by reset, so writing 0 has no effect.
- R8: A write from a master whose lock bit is 1 changes no register, whatever the address.
- R9: While force bit 1 is set, every core 1 request is judged as Non-secure, whatever `req_secure` says. Other masters are not affected.
- R10: An accepted write with bit 0 set to the clear register makes every region word return to its default at the next clock edge. Lock and force keep their values, and the clear register always reads 0.
- R11: Every configuration write presented in the cycle where a clear takes effect is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_master | input | 2 | Master code of the configuration access |
| cfg_addr | input | ADDR_W | Configuration word address (4 at defaults) |
| cfg_wdata | input | DATA_W | Configuration write data |
| cfg_rdata | output | DATA_W | Read data for `cfg_addr` |
| req_region | input | RIDX_W | Region index of the bus request (3 at defaults) |
| req_master | input | 2 | Master code of the bus request |
| req_secure | input | 1 | Request is Secure |
| req_priv | input | 1 | Request is Privileged |
| req_allow | output | 1 | Request is permitted |

## Verification
The hardest situation to reach from the ports is a configuration write that lands in the single cycle where a clear takes effect. It must be dropped, while the same write one cycle later must stick. The directed part of the bench issues a clear and follows it at once with a region write. The random part also mixes clear commands with back-to-back writes and scatters rare lock writes. The random run is split into phases with a reset between them, so both locked and unlocked masters are exercised against the reference model.

// File: rtl/bpc_pkg.sv
`timescale 1ns/1ps
package bpc_pkg;

  typedef enum logic [1:0] {
    M_CORE0 = 2'd0,
    M_CORE1 = 2'd1,
    M_DMA   = 2'd2,
    M_DEBUG = 2'd3
  } master_e;

  localparam int PERM_W   = 8;
  localparam int LOCK_W   = 4;
  localparam int CLASS_W  = 2;

  // permission word bit positions
  localparam int B_NSU = 0;
  localparam int B_NSP = 1;
  localparam int B_SU  = 2;
  localparam int B_SP  = 3;

  // register word addresses
  localparam int REG_LOCK        = 0;
  localparam int REG_FORCE       = 1;
  localparam int REG_CLEAR       = 2;
  localparam int REG_REGION_BASE = 4;

  localparam int FORCE_BIT = 1;
  localparam logic [LOCK_W-1:0] LOCK_RESET = 4'h4;

  function automatic logic [PERM_W-1:0] class_word(input logic [CLASS_W-1:0] cls);
    logic [PERM_W-1:0] w;
    case (cls)
      2'd0:    w = 8'hFF;
      2'd1:    w = 8'hFC;
      2'd2:    w = 8'hB8;
      default: w = 8'hF8;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/bpc_cfg_regs.sv
`timescale 1ns/1ps
module bpc_cfg_regs
  import bpc_pkg::*;
#(
  parameter int NUM_REGIONS = 6,
  parameter logic [CLASS_W*NUM_REGIONS-1:0] REGION_CLASS = '0,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_wr,
  input  logic [1:0]                    cfg_master,
  input  logic [ADDR_W-1:0]             cfg_addr,
  input  logic [DATA_W-1:0]             cfg_wdata,
  output logic [DATA_W-1:0]             cfg_rdata,
  output logic [PERM_W*NUM_REGIONS-1:0] region_flat,
  output logic                          force_ns
);

  logic [LOCK_W-1:0] lock_q, lock_d;
  logic              lock_en;
  logic              force_q, force_d, force_en;
  logic              clr_pulse_q, clr_pulse_d;
  logic              wr_ok;
  logic              unused_wdata;

  assign unused_wdata = ^cfg_wdata[DATA_W-1:PERM_W];

  // next-state for control registers
  always_comb begin
    wr_ok       = cfg_wr && !lock_q[cfg_master] && !clr_pulse_q;
    lock_en     = wr_ok && (cfg_addr == ADDR_W'(REG_LOCK));
    lock_d      = lock_q | cfg_wdata[LOCK_W-1:0];
    force_en    = wr_ok && (cfg_addr == ADDR_W'(REG_FORCE));
    force_d     = cfg_wdata[FORCE_BIT];
    clr_pulse_d = wr_ok && (cfg_addr == ADDR_W'(REG_CLEAR)) && cfg_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q      <= LOCK_RESET;
      force_q     <= 1'b0;
      clr_pulse_q <= 1'b0;
    end else begin
      if (lock_en)  lock_q  <= lock_d;
      if (force_en) force_q <= force_d;
      clr_pulse_q <= clr_pulse_d;
    end
  end

  // one permission word per region
  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    localparam logic [PERM_W-1:0] DEF = class_word(REGION_CLASS[CLASS_W*g +: CLASS_W]);
    logic [PERM_W-1:0] word_q, word_d;
    logic              word_en;

    always_comb begin
      word_en = clr_pulse_q ||
                (wr_ok && (cfg_addr == ADDR_W'(REG_REGION_BASE + g)));
      word_d  = clr_pulse_q ? DEF : cfg_wdata[PERM_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word_q <= DEF;
      else if (word_en) word_q <= word_d;
    end

    assign region_flat[PERM_W*g +: PERM_W] = word_q;
  end

  // combinational read-back
  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == ADDR_W'(REG_LOCK))  cfg_rdata[LOCK_W-1:0] = lock_q;
    if (cfg_addr == ADDR_W'(REG_FORCE)) cfg_rdata[FORCE_BIT]  = force_q;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (cfg_addr == ADDR_W'(REG_REGION_BASE + i))
        cfg_rdata[PERM_W-1:0] = region_flat[PERM_W*i +: PERM_W];
    end
  end

  assign force_ns = force_q;

endmodule

// File: rtl/bpc_perm_check.sv
`timescale 1ns/1ps
module bpc_perm_check
  import bpc_pkg::*;
#(
  parameter int NUM_REGIONS = 6,
  parameter int RIDX_W      = 3
) (
  input  logic [PERM_W*NUM_REGIONS-1:0] region_flat,
  input  logic                          force_ns,
  input  logic [RIDX_W-1:0]             req_region,
  input  logic [1:0]                    req_master,
  input  logic                          req_secure,
  input  logic                          req_priv,
  output logic                          req_allow
);

  logic [PERM_W-1:0] word;
  logic              hit;
  logic              eff_secure;
  logic              master_ok;
  logic              attr_ok;

  always_comb begin
    word = '0;
    hit  = 1'b0;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (req_region == RIDX_W'(i)) begin
        word = region_flat[PERM_W*i +: PERM_W];
        hit  = 1'b1;
      end
    end

    eff_secure = req_secure && !(force_ns && (req_master == M_CORE1));
    // master grant bits sit at 4 + master code
    master_ok  = word[{1'b1, req_master}];

    case ({eff_secure, req_priv})
      2'b11:   attr_ok = word[B_SP];
      2'b10:   attr_ok = word[B_SU] && word[B_SP];
      2'b01:   attr_ok = word[B_NSP];
      default: attr_ok = word[B_NSU] && word[B_NSP];
    endcase

    req_allow = hit && master_ok && attr_ok;
  end

endmodule

// File: rtl/bus_perm_ctrl.sv
`timescale 1ns/1ps
module bus_perm_ctrl
  import bpc_pkg::*;
#(
  parameter int NUM_REGIONS = 6,
  parameter logic [CLASS_W*NUM_REGIONS-1:0] REGION_CLASS = 12'h6E4,
  parameter int DATA_W = 32,
  localparam int ADDR_W = $clog2(REG_REGION_BASE + NUM_REGIONS),
  localparam int RIDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_master,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic [RIDX_W-1:0] req_region,
  input  logic [1:0]        req_master,
  input  logic              req_secure,
  input  logic              req_priv,
  output logic              req_allow
);

  logic [PERM_W*NUM_REGIONS-1:0] region_flat_w;
  logic                          force_ns_w;

  bpc_cfg_regs #(
    .NUM_REGIONS (NUM_REGIONS),
    .REGION_CLASS(REGION_CLASS),
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_master (cfg_master),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .region_flat(region_flat_w),
    .force_ns   (force_ns_w)
  );

  bpc_perm_check #(
    .NUM_REGIONS(NUM_REGIONS),
    .RIDX_W     (RIDX_W)
  ) u_check (
    .region_flat(region_flat_w),
    .force_ns   (force_ns_w),
    .req_region (req_region),
    .req_master (req_master),
    .req_secure (req_secure),
    .req_priv   (req_priv),
    .req_allow  (req_allow)
  );

endmodule

// File: rtl/bpc_checker.sv
`timescale 1ns/1ps
module bpc_checker
  import bpc_pkg::*;
#(
  parameter int NUM_REGIONS = 6,
  parameter logic [CLASS_W*NUM_REGIONS-1:0] REGION_CLASS = '0,
  parameter int RIDX_W = 3
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          cfg_wr,
  input logic [1:0]                    cfg_master,
  input logic [LOCK_W-1:0]             lock_q,
  input logic                          clr_pulse,
  input logic                          force_ns,
  input logic [PERM_W*NUM_REGIONS-1:0] region_flat,
  input logic [RIDX_W-1:0]             req_region,
  input logic [1:0]                    req_master,
  input logic                          req_secure,
  input logic                          req_priv,
  input logic                          req_allow
);

  function automatic logic [PERM_W*NUM_REGIONS-1:0] all_defaults();
    logic [PERM_W*NUM_REGIONS-1:0] v;
    for (int i = 0; i < NUM_REGIONS; i++)
      v[PERM_W*i +: PERM_W] = class_word(REGION_CLASS[CLASS_W*i +: CLASS_W]);
    return v;
  endfunction

  localparam logic [PERM_W*NUM_REGIONS-1:0] DEF_FLAT = all_defaults();

  logic [PERM_W-1:0] sel_word;
  always_comb begin
    sel_word = '0;
    for (int i = 0; i < NUM_REGIONS; i++)
      if (req_region == RIDX_W'(i)) sel_word = region_flat[PERM_W*i +: PERM_W];
  end

  a_r7_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ((lock_q & $past(lock_q)) == $past(lock_q)));

  a_r8_locked_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && lock_q[cfg_master] && !clr_pulse) |=>
      ($stable(region_flat) && $stable(lock_q) && $stable(force_ns) && !clr_pulse));

  a_r10_clear_restores: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |=> ((region_flat == DEF_FLAT) && $stable(lock_q) && $stable(force_ns)));

  a_r10_clear_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |=> !clr_pulse);

  a_r5_out_of_range_denied: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(req_region) >= NUM_REGIONS) |-> !req_allow);

  a_r9_forced_core1_nonsecure: assert property (@(posedge clk) disable iff (!rst_n)
    (force_ns && (req_master == 2'd1) && req_priv && req_allow) |-> sel_word[B_NSP]);

  a_r4_ns_unpriv_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
    (req_allow && !req_secure && !req_priv) |-> (sel_word[B_NSU] && sel_word[B_NSP]));

  a_r2_master_granted: assert property (@(posedge clk) disable iff (!rst_n)
    req_allow |-> sel_word[4 + int'(req_master)]);

endmodule

bind bus_perm_ctrl bpc_checker #(
  .NUM_REGIONS (NUM_REGIONS),
  .REGION_CLASS(REGION_CLASS),
  .RIDX_W      (RIDX_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_wr     (cfg_wr),
  .cfg_master (cfg_master),
  .lock_q     (u_regs.lock_q),
  .clr_pulse  (u_regs.clr_pulse_q),
  .force_ns   (force_ns_w),
  .region_flat(region_flat_w),
  .req_region (req_region),
  .req_master (req_master),
  .req_secure (req_secure),
  .req_priv   (req_priv),
  .req_allow  (req_allow)
);

// File: tb/tb_bus_perm_ctrl.sv
`timescale 1ns/1ps
module tb_bus_perm_ctrl;

  localparam int NREG = 6;
  localparam logic [11:0] CLS = 12'h6E4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr;
  logic [1:0]  cfg_master;
  logic [3:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic [2:0]  req_region;
  logic [1:0]  req_master;
  logic        req_secure;
  logic        req_priv;
  logic        req_allow;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [7:0] m_reg [NREG];
  logic [3:0] m_lock;
  logic       m_force;
  logic       m_pend;

  bus_perm_ctrl #(.NUM_REGIONS(NREG), .REGION_CLASS(CLS), .DATA_W(32)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_master(cfg_master),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .req_region(req_region), .req_master(req_master), .req_secure(req_secure),
    .req_priv(req_priv), .req_allow(req_allow)
  );

  always #5 clk = ~clk;

  function automatic logic [7:0] dflt(input int r);
    case ((CLS >> (2 * r)) & 12'h3)
      12'd0:   return 8'hFF;
      12'd1:   return 8'hFC;
      12'd2:   return 8'hB8;
      default: return 8'hF8;
    endcase
  endfunction

  function automatic logic exp_allow(input int rg, input int m, input bit s, input bit p);
    logic [7:0] w;
    bit sec;
    if (rg >= NREG) return 1'b0;
    w = m_reg[rg];
    sec = s && !(m_force && m == 1);
    if (!w[4 + m]) return 1'b0;
    if (sec && p)  return w[3];
    if (sec)       return w[3] && w[2];
    if (p)         return w[1];
    return w[1] && w[0];
  endfunction

  function automatic logic [31:0] exp_read(input int a);
    if (a == 0) return {28'd0, m_lock};
    if (a == 1) return {30'd0, m_force, 1'b0};
    if (a >= 4 && a < 4 + NREG) return {24'd0, m_reg[a - 4]};
    return 32'd0;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NREG; i++) m_reg[i] = dflt(i);
    m_lock = 4'h4; m_force = 1'b0; m_pend = 1'b0;
  endtask

  task automatic model_edge(input bit wr, input int m, input int a, input logic [31:0] d);
    bit np = 0;
    if (m_pend) begin
      for (int i = 0; i < NREG; i++) m_reg[i] = dflt(i);
    end else if (wr && !m_lock[m]) begin
      if (a == 0) m_lock = m_lock | d[3:0];
      else if (a == 1) m_force = d[1];
      else if (a == 2) np = d[0];
      else if (a >= 4 && a < 4 + NREG) m_reg[a - 4] = d[7:0];
    end
    m_pend = np;
  endtask

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cfg_wr = 0; cfg_master = 0; cfg_addr = 0; cfg_wdata = 0;
    req_region = 0; req_master = 0; req_secure = 0; req_priv = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  task automatic step(input string tag, input bit wr, input int wm, input int a,
                      input logic [31:0] d, input int rg, input int rm,
                      input bit s, input bit p);
    @(negedge clk);
    cfg_wr = wr; cfg_master = 2'(wm); cfg_addr = 4'(a); cfg_wdata = d;
    req_region = 3'(rg); req_master = 2'(rm); req_secure = s; req_priv = p;
    #2;
    chk({tag, " allow"}, {31'd0, req_allow}, {31'd0, exp_allow(rg, rm, s, p)});
    chk({tag, " read"}, cfg_rdata, exp_read(a));
    @(posedge clk);
    #1;
    model_edge(wr, wm, a, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int a, r;
    void'($urandom(32'd20240611));
    do_reset();

    // R1 / R6: reset values and full map read-back, unmapped reads 0
    for (int i = 0; i < 16; i++) step("R1 R6 reset map", 0, 0, i, 32'hFFFF_FFFF, i % 8, 3, 1, 1);

    // R2: only core 1 grant bit set
    step("R2 write", 1, 0, 4, 32'h0000_002F, 0, 0, 1, 1);
    for (int m = 0; m < 4; m++) step("R2 master bit", 0, 0, 4, 0, 0, m, 1, 1);

    // R3 / R4: privileged grants only
    step("R3 write", 1, 0, 4, 32'hFFFF_FFFA, 0, 0, 1, 1);
    for (int k = 0; k < 4; k++) step("R3 R4 attr", 0, 0, 4, 0, 0, 0, k[1], k[0]);
    // R4: unprivileged bits without their privileged partner
    step("R4 write", 1, 0, 4, 32'h0000_00F5, 0, 0, 1, 1);
    for (int k = 0; k < 4; k++) step("R4 attr", 0, 0, 4, 0, 0, 3, k[1], k[0]);

    // R5: regions beyond the count
    step("R5 range", 0, 0, 0, 0, 6, 3, 1, 1);
    step("R5 range", 0, 0, 0, 0, 7, 0, 1, 1);
    step("R5 in range", 0, 0, 0, 0, 5, 0, 1, 1);

    // R9: force non-secure on core 1
    step("R9 write", 1, 0, 4, 32'h0000_00F8, 0, 1, 1, 1);
    step("R9 before", 1, 0, 1, 32'h0000_0002, 0, 1, 1, 1);
    step("R9 forced", 0, 0, 1, 0, 0, 1, 1, 1);
    step("R9 core0 kept", 0, 0, 1, 0, 0, 0, 1, 1);

    // R10 / R11: clear, then a write that lands on the clear edge
    step("R10 clear", 1, 0, 2, 32'h0000_0001, 0, 0, 1, 1);
    step("R11 dropped", 1, 0, 4, 32'h0000_0000, 0, 0, 1, 1);
    step("R10 restored", 0, 0, 4, 0, 0, 0, 0, 0);
    step("R10 lock kept", 0, 0, 0, 0, 0, 0, 1, 1);
    step("R10 force kept", 0, 0, 1, 0, 0, 1, 1, 1);
    step("R10 reads 0", 0, 0, 2, 0, 0, 0, 1, 1);

    // R8: DMA locked from reset
    step("R8 dma write", 1, 2, 5, 32'h0000_0000, 1, 2, 1, 1);
    step("R8 dma dropped", 0, 0, 5, 0, 1, 2, 1, 1);

    // R7 / R8: lock core 0, try to unlock, write from locked and unlocked masters
    step("R7 lock core0", 1, 0, 0, 32'h0000_0001, 0, 0, 1, 1);
    step("R8 core0 write", 1, 0, 6, 32'h0000_0000, 2, 0, 1, 1);
    step("R7 unlock try", 1, 1, 0, 32'h0000_0000, 2, 0, 1, 1);
    step("R7 still set", 0, 0, 0, 0, 2, 0, 1, 1);
    step("R8 core1 write", 1, 1, 6, 32'h0000_0030, 2, 1, 1, 1);
    step("R8 core1 ok", 0, 0, 6, 0, 2, 1, 1, 1);
    step("R8 core0 clear", 1, 0, 2, 32'h0000_0001, 2, 0, 1, 1);
    step("R8 no clear", 0, 0, 6, 0, 2, 1, 1, 1);

    // constrained random phases
    for (int ph = 0; ph < 4; ph++) begin
      do_reset();
      for (int n = 0; n < 800; n++) begin
        r = int'($urandom % 64);
        if (r == 0)       a = 0;
        else if (r < 4)   a = 1;
        else if (r < 7)   a = 2;
        else if (r < 10)  a = (r == 7) ? 3 : 10 + int'($urandom % 6);
        else              a = 4 + int'($urandom % NREG);
        step("rand", ($urandom % 10) < 4, int'($urandom % 4), a, $urandom,
             int'($urandom % 8), int'($urandom % 4), 1'($urandom), 1'($urandom));
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule